// File: doc/BRIEF.md
# Protected Register Unlock Sequencer

The sequencer holds a chip's write-protected control bits behind a three-write key. Software opens the lock by writing 0x59, then 0x16, then 0x88 to a dedicated key register. The three writes must come as back-to-back bus accesses. Once the last key word lands, the unlock status goes high and stays high. It stays high until software writes anything to the key register again.

A read of the key register reports the lock state in bit 0. The block also qualifies writes that fall inside a window of protected addresses, so that the registers in that window are updated only while the lock is open.

Any bus access that comes between two key writes discards the partial key. This covers a read of any address, including the key register itself, and a write to any other address. Bus idle cycles with no access do not count as accesses. The block does not arbitrate the bus, and it does not hold the protected registers.

Top module: `key_unlock_seq`

## Requirements
- R1: Out of reset the block is locked: `unlocked_o` is 0, and a read of the key register returns 0.
- R2: Three writes of the full words 0x59, 0x16 and 0x88, in that order, to the key register at address 0x40 open the lock. Between them there may be idle cycles but no other access. `unlocked_o` goes to 1 in the cycle after the third write.
- R3: A read of the key register returns 1 in bit 0 while unlocked and 0 while locked, with all upper bits 0. A read of any other address returns 0. Read data is combinational in the cycle of the read.
- R4: While locked, any other access between key writes returns the sequencer to its start. This means a read of any address, or a write to an address other than 0x40.
- R5: While locked, a key-register write whose word differs from the expected key word returns the sequencer to its start. If that word equals 0x59, it counts as the first key word of a new attempt. Upper data bits must be zero for a word to match.
- R6: While unlocked, a write of any value to the key register re-locks the block. `unlocked_o` goes to 0 in the next cycle and the key must be entered again.
- R7: While unlocked, reads and writes to other addresses leave the lock open.
- R8: `prot_we_o` is high in the cycle of a write to an address in 0x20 to 0x27 only while the lock is open. It is 0 otherwise.
- R9: When `bus_we_i` and `bus_re_i` are both high, the cycle is treated as a write alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe (ignored when write strobe high) |
| bus_addr_i | input | 8 | Access address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the read cycle |
| unlocked_o | output | 1 | Lock open status |
| prot_we_o | output | 1 | Qualified write enable for the protected window |

## Verification
A wrong key step inside the sequencer has no effect at the ports until the next write to the key register. The error then shows as `unlocked_o` rising one write too early, or not rising at all, one cycle after that write. `bus_rdata_o` shows the same error in the cycle of any later read of the key register. A wrong open bit shows at once on `prot_we_o` for any write into the protected window.

// File: rtl/klk_pkg.sv
package klk_pkg;
  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_KEY_WR  = 2'd1,
    ACC_FOREIGN = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/klk_access_dec.sv
module klk_access_dec
  import klk_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int KEY_ADDR  = 'h40,
  parameter int PROT_BASE = 'h20,
  parameter int PROT_CNT  = 8
) (
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic              key_rd_o,
  output logic              prot_hit_o
);
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(PROT_BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(PROT_BASE + PROT_CNT);

  logic key_sel, rd;
  logic [ADDR_W:0] addr_x;

  assign addr_x  = {1'b0, addr_i};
  assign key_sel = (addr_i == ADDR_W'(KEY_ADDR));
  assign rd      = re_i & ~we_i;  // write wins
  assign key_rd_o   = rd & key_sel;
  assign prot_hit_o = we_i & (addr_x >= LO) & (addr_x < HI);

  always_comb begin
    if (we_i && key_sel)  kind_o = ACC_KEY_WR;
    else if (we_i || rd)  kind_o = ACC_FOREIGN;
    else                  kind_o = ACC_NONE;
  end
endmodule

// File: rtl/klk_key_fsm.sv
module klk_key_fsm
  import klk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int KEY_LEN = 3,
  parameter logic [KEY_LEN*8-1:0] KEY = 24'h591688
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_kind_e         kind_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o
);
  localparam int STEP_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(KEY_LEN - 1);

  logic [DATA_W-1:0] key_word [KEY_LEN];
  for (genvar i = 0; i < KEY_LEN; i++) begin : g_key
    assign key_word[i] = DATA_W'(KEY[(KEY_LEN-1-i)*8 +: 8]);
  end

  logic [STEP_W-1:0] step_q, step_d;
  logic              open_q, open_d;
  logic [DATA_W-1:0] expect_w;

  assign expect_w = key_word[step_q];

  always_comb begin
    step_d = step_q;
    open_d = open_q;
    if (open_q) begin
      if (kind_i == ACC_KEY_WR) open_d = 1'b0;
      step_d = '0;
    end else begin
      unique case (kind_i)
        ACC_KEY_WR: begin
          if (wdata_i == expect_w) begin
            if (step_q == LAST) begin
              open_d = 1'b1;
              step_d = '0;
            end else begin
              step_d = step_q + STEP_W'(1);
            end
          end else if (wdata_i == key_word[0]) begin
            step_d = STEP_W'(1);  // restart
          end else begin
            step_d = '0;
          end
        end
        ACC_FOREIGN: step_d = '0;
        default:     step_d = step_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      open_q <= 1'b0;
    end else begin
      step_q <= step_d;
      open_q <= open_d;
    end
  end

  assign open_o = open_q;
endmodule

// File: rtl/klk_prot_gate.sv
module klk_prot_gate #(
  parameter int DATA_W = 32
) (
  input  logic              open_i,
  input  logic              key_rd_i,
  input  logic              prot_hit_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              prot_we_o
);
  assign rdata_o   = key_rd_i ? DATA_W'(open_i) : '0;
  assign prot_we_o = prot_hit_i & open_i;
endmodule

// File: rtl/key_unlock_seq.sv
module key_unlock_seq
  import klk_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int KEY_ADDR  = 'h40,
  parameter int PROT_BASE = 'h20,
  parameter int PROT_CNT  = 8,
  parameter int KEY_LEN   = 3,
  parameter logic [KEY_LEN*8-1:0] KEY = 24'h591688
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              unlocked_o,
  output logic              prot_we_o
);
  acc_kind_e kind;
  logic      key_rd, prot_hit, open;

  klk_access_dec #(
    .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR),
    .PROT_BASE(PROT_BASE), .PROT_CNT(PROT_CNT)
  ) u_dec (
    .we_i(bus_we_i), .re_i(bus_re_i), .addr_i(bus_addr_i),
    .kind_o(kind), .key_rd_o(key_rd), .prot_hit_o(prot_hit)
  );

  klk_key_fsm #(
    .DATA_W(DATA_W), .KEY_LEN(KEY_LEN), .KEY(KEY)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .kind_i(kind),
    .wdata_i(bus_wdata_i), .open_o(open)
  );

  klk_prot_gate #(.DATA_W(DATA_W)) u_gate (
    .open_i(open), .key_rd_i(key_rd), .prot_hit_i(prot_hit),
    .rdata_o(bus_rdata_o), .prot_we_o(prot_we_o)
  );

  assign unlocked_o = open;
endmodule

// File: rtl/key_unlock_seq_chk.sv
module key_unlock_seq_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int KEY_ADDR = 'h40,
  parameter int KEY_LEN  = 3,
  parameter logic [KEY_LEN*8-1:0] KEY = 24'h591688
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic              bus_re_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              unlocked_o,
  input logic              prot_we_o
);
  logic key_wr, foreign, key_rd;
  assign key_wr  = bus_we_i && (bus_addr_i == ADDR_W'(KEY_ADDR));
  assign key_rd  = bus_re_i && !bus_we_i && (bus_addr_i == ADDR_W'(KEY_ADDR));
  assign foreign = (bus_re_i && !bus_we_i) || (bus_we_i && !key_wr);

  // R2: opening follows a key write carrying the last key word
  assert_open_on_last_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(key_wr && bus_wdata_i == DATA_W'(KEY[7:0])));

  // R4: a foreign access while locked never opens the lock next cycle
  assert_foreign_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && foreign) |=> !unlocked_o);

  // R6: key write while open closes the lock
  assert_relock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && key_wr) |=> !unlocked_o);

  // R7: closing only happens through a key write
  assert_close_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(unlocked_o) |-> $past(key_wr));

  // R8: protected writes only while open
  assert_prot_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_we_o |-> (unlocked_o && bus_we_i));

  // R3: key-register read reflects lock state
  assert_read_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_rd |-> (bus_rdata_o == DATA_W'(unlocked_o)));
endmodule

bind key_unlock_seq key_unlock_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
  .KEY_LEN(KEY_LEN), .KEY(KEY)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_re_i(bus_re_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .unlocked_o(unlocked_o), .prot_we_o(prot_we_o)
);

// File: tb/sim_key_unlock_seq.sv
module sim_key_unlock_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] KA = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        unl, pwe;

  int n_chk = 0, n_bad = 0;
  int m_step = 0;
  bit m_open = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_unlock_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .unlocked_o(unl), .prot_we_o(pwe)
  );

  function automatic logic [31:0] key_at(int i);
    case (i)
      0: return 32'h59;
      1: return 32'h16;
      default: return 32'h88;
    endcase
  endfunction

  function automatic logic [31:0] exp_rdata(bit w, bit r, logic [7:0] a, bit op);
    return (!w && r && a == KA) ? {31'b0, op} : 32'b0;
  endfunction

  function automatic bit exp_pwe(bit w, logic [7:0] a, bit op);
    return w && a >= 8'h20 && a <= 8'h27 && op;
  endfunction

  task automatic model_upd(bit w, bit r, logic [7:0] a, logic [31:0] d);
    if (m_open) begin
      if (w && a == KA) m_open = 1'b0;
      m_step = 0;
    end else if (w && a == KA) begin
      if (d == key_at(m_step)) begin
        if (m_step == 2) begin m_open = 1'b1; m_step = 0; end
        else m_step++;
      end else if (d == 32'h59) m_step = 1;
      else m_step = 0;
    end else if (w || r) m_step = 0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, check combinational outputs, advance one edge
  task automatic acc(bit w, bit r, logic [7:0] a, logic [31:0] d, string req);
    @(negedge clk);
    check(req, {31'b0, unl}, {31'b0, m_open});
    we = w; re = r; addr = a; wdata = d;
    #1;
    check("R3", rdata, exp_rdata(w, r, a, m_open));
    check("R8", {31'b0, pwe}, {31'b0, exp_pwe(w, a, m_open)});
    @(posedge clk);
    model_upd(w, r, a, d);
  endtask

  task automatic idle(); acc(0, 0, 8'h00, 32'h0, "R2"); endtask

  task automatic key_seq(string req);
    acc(1, 0, KA, 32'h59, req);
    acc(1, 0, KA, 32'h16, req);
    acc(1, 0, KA, 32'h88, req);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 3);
    check("R1", {31'b0, unl}, 32'h0);
    rst_n = 1'b1;
    acc(0, 1, KA, 32'h0, "R1");  // read returns 0 while locked
    idle();
    // R2 basic open, with idle gap
    acc(1, 0, KA, 32'h59, "R2"); idle();
    acc(1, 0, KA, 32'h16, "R2"); idle();
    acc(1, 0, KA, 32'h88, "R2"); idle();
    check("R2", {31'b0, unl}, 32'h1);
    acc(0, 1, KA, 32'h0, "R3");
    // R7 other accesses keep it open
    acc(1, 0, 8'h21, 32'hdead, "R7");
    acc(0, 1, 8'h10, 32'h0, "R7");
    idle();
    check("R7", {31'b0, unl}, 32'h1);
    // R6 relock by any value
    acc(1, 0, KA, 32'hffff_ffff, "R6"); idle();
    check("R6", {31'b0, unl}, 32'h0);
    acc(1, 0, 8'h22, 32'h1, "R8");
    // R4 read of key reg aborts
    acc(1, 0, KA, 32'h59, "R4"); acc(0, 1, KA, 0, "R4");
    acc(1, 0, KA, 32'h16, "R4"); acc(1, 0, KA, 32'h88, "R4"); idle();
    check("R4", {31'b0, unl}, 32'h0);
    // R4 write elsewhere aborts
    acc(1, 0, KA, 32'h59, "R4"); acc(1, 0, KA, 32'h16, "R4");
    acc(1, 0, 8'h41, 32'h0, "R4"); acc(1, 0, KA, 32'h88, "R4"); idle();
    check("R4", {31'b0, unl}, 32'h0);
    // R5 repeated first word restarts; upper bits break match
    acc(1, 0, KA, 32'h59, "R5"); acc(1, 0, KA, 32'h59, "R5");
    acc(1, 0, KA, 32'h16, "R5"); acc(1, 0, KA, 32'h88, "R5"); idle();
    check("R5", {31'b0, unl}, 32'h1);
    acc(1, 0, KA, 32'h0, "R6"); idle();
    acc(1, 0, KA, 32'h159, "R5"); acc(1, 0, KA, 32'h16, "R5");
    acc(1, 0, KA, 32'h88, "R5"); idle();
    check("R5", {31'b0, unl}, 32'h0);
    // R9 write wins over read: counts as key write
    acc(1, 1, KA, 32'h59, "R9"); acc(1, 1, KA, 32'h16, "R9");
    acc(1, 1, KA, 32'h88, "R9"); idle();
    check("R9", {31'b0, unl}, 32'h1);
    acc(1, 0, KA, 32'h0, "R6");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 9);
      bit w = $urandom_range(0, 3) != 0;
      bit r = $urandom_range(0, 1);
      logic [7:0] a = (sel < 6) ? KA : (sel < 8) ? 8'(8'h20 + $urandom_range(0, 9)) : 8'($urandom);
      logic [31:0] d = ($urandom_range(0, 3) != 0) ? key_at($urandom_range(0, 2)) : $urandom;
      if (sel == 9) key_seq("R2");
      else acc(w, r, a, d, "R5");
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule